// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences an N-bit charge-redistribution converter with three bottom-plate references. These are the supply, a common-mode level at half the supply, and ground. A single pulse on the start input begins a conversion. The conversion then occupies N+1 cycles of the conversion clock, so that clock runs at N+1 times the sample rate. For example, eight bits at roughly 278 samples per second needs a 2.5 kHz conversion clock.

The first cycle is split in two halves. In the first half every bottom plate tracks the analogue input while the top plates are held at common mode. In the second half every bottom plate moves to common mode, which is the inversion step. In each of the N cycles that follow, the block reads the comparator once. It then ties one more capacitor, working from the largest down to the smallest, to the supply when the comparator is high or to ground when it is low. The decisions build the result MSB first. The result is published with a one-cycle done strobe.

The capacitor array, the comparator and the switches themselves sit outside the block. The block only drives their select lines. An enable input parks every switch at common mode and freezes the published result.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every capacitor select reads common mode (01), the top-plate switch is open (0), the result is 0 and done is 0.
- R2: Capacitor k drives its select on sel_o[2k+1:2k] with the code 00 = input, 01 = common mode, 10 = supply, 11 = ground.
- R3: A start pulse seen at a rising edge while idle and enabled begins the sampling cycle. In the high half of that cycle all selects are 00 and top_cm_o is 1. In the low half all selects are 01 and top_cm_o is 0.
- R4: At the rising edge that begins conversion cycle i (i = 1..N), the comparator is read. Capacitor N-i then selects 10 if it was high and 11 if it was low, and keeps that value to the end of the conversion. Capacitors below it stay at 01.
- R5: The decision taken at the start of cycle i becomes result bit N-i, so the first decision is the MSB. At the edge that ends cycle N, the full word appears on result_o and done_o is 1 for exactly one cycle. With an ideal comparator and array, the result equals the input code at every code including 0 and 2^N-1.
- R6: result_o changes only at an edge where done_o rises.
- R7: A start pulse during cycles 1..N of a conversion is ignored. The running conversion's selects and result are unaffected, and no new sampling cycle follows it.
- R8: A start present at the edge that ends cycle N is accepted. The sampling cycle of the next conversion then runs in the same cycle as the done strobe.
- R9: While en_i is 0, all selects read 01 and top_cm_o reads 0 in that same cycle. Start is ignored, done stays 0 and result_o holds its value.
- R10: Dropping en_i during a conversion abandons it. No done strobe follows, result_o keeps the previous result, and the block stays idle with all selects at 01 once enable returns.
- R11: When idle and enabled, all selects read 01 and top_cm_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; the sampling cycle uses both halves |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low parks the switches and aborts conversion |
| start_i | input | 1 | Conversion request, sampled on the rising edge |
| cmp_i | input | 1 | Comparator output, read at each decision edge |
| sel_o | output | 2*NBITS | Two-bit switch select per bottom plate, capacitor k at [2k+1:2k] |
| top_cm_o | output | 1 | Closes the top-plate common-mode switch |
| result_o | output | NBITS | Last completed conversion word |
| done_o | output | 1 | One-cycle strobe when result_o is updated |

## Verification
On every cycle, the embedded properties check the ordering and timing rules. The sampling cycle always hands over to the MSB decision with the inversion flag already set. The bit index only steps down by one while a conversion runs, whatever start does. Done never lasts two cycles, never follows a disabled cycle, and the result never moves without it. What only the bench's scenarios can show is the values on the lines. These are the select pattern in each half-cycle and each bit cycle, the result word against an ideal array model and against forced comparator patterns, back-to-back chaining, and the immediate parking and held result when enable drops.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

    typedef enum logic [1:0] {
        SW_INPUT  = 2'b00,
        SW_CMODE  = 2'b01,
        SW_SUPPLY = 2'b10,
        SW_GROUND = 2'b11
    } sw_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        PM_PARK    = 2'd0,
        PM_TRACK   = 2'd1,
        PM_INVERT  = 2'd2,
        PM_RESOLVE = 2'd3
    } plate_mode_e;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_conv_pkg::*;
#(
    parameter int NBITS = 8,
    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic             cmp_i,
    output seq_state_e       state_o,
    output logic [IW-1:0]    idx_o,
    output logic [NBITS-1:0] dec_o,
    output logic [NBITS-1:0] result_o,
    output logic             done_o
);

    typedef struct packed {
        seq_state_e       st;
        logic [IW-1:0]    idx;
        logic [NBITS-1:0] dec;
        logic [NBITS-1:0] res;
        logic             done;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        if (!en_i) begin
            nxt_d.st = ST_IDLE;
        end else begin
            case (cur_q.st)
                ST_IDLE: begin
                    if (start_i) begin
                        nxt_d.st  = ST_SAMPLE;
                        nxt_d.dec = '0;
                    end
                end
                ST_SAMPLE: begin
                    nxt_d.st             = ST_CONV;
                    nxt_d.idx            = IW'(NBITS - 1);
                    nxt_d.dec[NBITS - 1] = cmp_i;
                end
                ST_CONV: begin
                    if (cur_q.idx == '0) begin
                        nxt_d.res  = cur_q.dec;
                        nxt_d.done = 1'b1;
                        if (start_i) begin
                            nxt_d.st  = ST_SAMPLE;
                            nxt_d.dec = '0;
                        end else begin
                            nxt_d.st = ST_IDLE;
                        end
                    end else begin
                        nxt_d.idx                       = cur_q.idx - IW'(1);
                        nxt_d.dec[cur_q.idx - IW'(1)]   = cmp_i;
                    end
                end
                default: nxt_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, idx: '0, dec: '0, res: '0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o  = cur_q.st;
    assign idx_o    = cur_q.idx;
    assign dec_o    = cur_q.dec;
    assign result_o = cur_q.res;
    assign done_o   = cur_q.done;

    // R5: the sampling cycle always hands over to the MSB decision
    a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_SAMPLE && en_i) |=> (cur_q.st == ST_CONV && cur_q.idx == IW'(NBITS - 1)));

    // R7: a running conversion steps down one bit per cycle regardless of start
    a_r7_busy_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_CONV && cur_q.idx != '0 && en_i)
        |=> (cur_q.st == ST_CONV && cur_q.idx == $past(cur_q.idx) - IW'(1)));

    // R5: done lasts a single cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the published word moves only together with done
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

endmodule

// File: rtl/sar_phase.sv
module sar_phase
    import sar_conv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state_i,
    output logic       inv_o
);

    logic inv_d, inv_q;

    always_comb begin
        inv_d = (state_i == ST_SAMPLE);
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
        end else begin
            inv_q <= inv_d;
        end
    end

    assign inv_o = inv_q;

endmodule

// File: rtl/sar_plate_map.sv
module sar_plate_map
    import sar_conv_pkg::*;
#(
    parameter int NBITS = 8,
    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  plate_mode_e        mode_i,
    input  logic [IW-1:0]      idx_i,
    input  logic [NBITS-1:0]   dec_i,
    output logic [2*NBITS-1:0] sel_o,
    output logic               top_cm_o
);

    for (genvar k = 0; k < NBITS; k++) begin : g_cap
        sw_sel_e sel_d;
        always_comb begin
            case (mode_i)
                PM_TRACK:   sel_d = SW_INPUT;
                PM_INVERT:  sel_d = SW_CMODE;
                PM_RESOLVE: begin
                    if (k >= int'(idx_i)) begin
                        sel_d = dec_i[k] ? SW_SUPPLY : SW_GROUND;
                    end else begin
                        sel_d = SW_CMODE;
                    end
                end
                default:    sel_d = SW_CMODE;
            endcase
        end
        assign sel_o[2*k +: 2] = sel_d;
    end

    assign top_cm_o = (mode_i == PM_TRACK);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               start_i,
    input  logic               cmp_i,
    output logic [2*NBITS-1:0] sel_o,
    output logic               top_cm_o,
    output logic [NBITS-1:0]   result_o,
    output logic               done_o
);

    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

    seq_state_e       st;
    logic [IW-1:0]    idx;
    logic [NBITS-1:0] dec;
    logic             inv;
    plate_mode_e      mode_d;

    sar_seq #(.NBITS(NBITS)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .start_i  (start_i),
        .cmp_i    (cmp_i),
        .state_o  (st),
        .idx_o    (idx),
        .dec_o    (dec),
        .result_o (result_o),
        .done_o   (done_o)
    );

    sar_phase phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (st),
        .inv_o   (inv)
    );

    always_comb begin
        if (!en_i) begin
            mode_d = PM_PARK;
        end else begin
            case (st)
                ST_SAMPLE: mode_d = inv ? PM_INVERT : PM_TRACK;
                ST_CONV:   mode_d = PM_RESOLVE;
                default:   mode_d = PM_PARK;
            endcase
        end
    end

    sar_plate_map #(.NBITS(NBITS)) map_i (
        .mode_i   (mode_d),
        .idx_i    (idx),
        .dec_i    (dec),
        .sel_o    (sel_o),
        .top_cm_o (top_cm_o)
    );

    // R3: the inversion half has begun before the first decision edge
    a_r3_invert_before_decide: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SAMPLE) |-> inv);

    // R9: no done strobe follows a disabled cycle
    a_r9_no_done_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !done_o);

endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;

    localparam int NB = 8;
    localparam logic [2*NB-1:0] ALL_CM = {NB{2'b01}};
    localparam logic [2*NB-1:0] ALL_IN = '0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic start = 1'b0;
    logic cmp;
    logic [2*NB-1:0] sel;
    logic top_cm;
    logic [NB-1:0] result;
    logic done;

    int  vin = 0;
    bit  use_model = 1'b1;
    logic forced_cmp = 1'b0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  ended = 1'b0;

    always #4 clk = ~clk;

    sar_conv_ctrl #(.NBITS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .start_i(start), .cmp_i(cmp),
        .sel_o(sel), .top_cm_o(top_cm), .result_o(result), .done_o(done)
    );

    // ideal array and comparator, level in half-LSB units
    function automatic logic model_cmp(logic [2*NB-1:0] s, int v);
        int lvl = 0;
        for (int k = 0; k < NB; k++) begin
            if (s[2*k +: 2] == 2'b10) lvl += 2 * (1 << k);
            else if (s[2*k +: 2] != 2'b11) lvl += (1 << k);
        end
        return (2 * v + 1 > lvl);
    endfunction

    always_comb cmp = use_model ? model_cmp(sel, vin) : forced_cmp;

    function automatic logic [2*NB-1:0] exp_sel(int cyc, logic [NB-1:0] bits);
        logic [2*NB-1:0] r;
        for (int k = 0; k < NB; k++) begin
            if (k >= NB - cyc) r[2*k +: 2] = bits[k] ? 2'b10 : 2'b11;
            else r[2*k +: 2] = 2'b01;
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // caller stands at posedge+2; chained means start already taken at the last edge
    task automatic run_conv(logic [NB-1:0] code, bit model, bit poke, bit chain, bit chained);
        vin = int'(code);
        use_model = model;
        forced_cmp = code[NB-1];
        if (!chained) begin
            start = 1'b1;
            @(posedge clk); #2;
        end
        start = 1'b0;
        chk(sel == ALL_IN && top_cm, "R3", "sample half sel/top", sel, ALL_IN);
        #4;
        chk(sel == ALL_CM && !top_cm, "R3", "invert half sel/top", sel, ALL_CM);
        @(posedge clk); #2;
        for (int i = 1; i <= NB; i++) begin
            if (i > 1) begin
                @(posedge clk); #2;
            end
            start = 1'b0;
            chk(sel == exp_sel(i, code), "R4", "R2 select in bit cycle", sel, exp_sel(i, code));
            chk(!done && !top_cm, "R5", "no done while converting", done, 0);
            if (poke && i == 3) start = 1'b1;
            if (chain && i == NB) start = 1'b1;
            if (i < NB) forced_cmp = code[NB-1-i];
        end
        @(posedge clk); #2;
        chk(done && result == code, poke ? "R7" : "R5", "done/result", result, code);
        if (!chain) begin
            chk(sel == ALL_CM && !top_cm, "R11", "parked after done", sel, ALL_CM);
            @(posedge clk); #2;
            chk(!done, "R5", "done one cycle", done, 0);
            chk(sel == ALL_CM && !top_cm, poke ? "R7" : "R11", "still idle", sel, ALL_CM);
        end else begin
            chk(sel == ALL_IN && top_cm, "R8", "chained sample with done", sel, ALL_IN);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [NB-1:0] held;
        void'($urandom(32'h5A17));
        #3;
        chk(sel == ALL_CM && !top_cm && result == 0 && !done, "R1", "in reset", sel, ALL_CM);
        @(posedge clk); @(posedge clk); #2;
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk(sel == ALL_CM && !top_cm && result == 0 && !done, "R1", "after reset", result, 0);
        en = 1'b1;
        @(posedge clk); #2;
        chk(sel == ALL_CM && !top_cm, "R11", "idle enabled", sel, ALL_CM);

        // directed corner codes through the ideal model
        run_conv(8'h00, 1, 0, 0, 0);
        run_conv(8'hFF, 1, 0, 0, 0);
        run_conv(8'h80, 1, 0, 0, 0);
        run_conv(8'h7F, 1, 0, 0, 0);
        run_conv(8'h01, 1, 0, 0, 0);
        // forced comparator patterns
        run_conv(8'hA5, 0, 0, 0, 0);
        run_conv(8'h5A, 0, 0, 0, 0);
        // start while busy is ignored
        run_conv(8'h3C, 1, 1, 0, 0);

        // back-to-back chain
        run_conv(8'h11, 1, 0, 1, 0);
        run_conv(8'hEE, 0, 0, 1, 1);
        run_conv(8'h42, 1, 0, 0, 1);

        // enable low: start ignored, parked, result held
        held = result;
        en = 1'b0;
        start = 1'b1;
        #1;
        chk(sel == ALL_CM && !top_cm, "R9", "parked when disabled", sel, ALL_CM);
        for (int i = 0; i < NB + 2; i++) begin
            @(posedge clk); #2;
            start = 1'b0;
            chk(sel == ALL_CM && !top_cm && !done && result == held, "R9", "disabled quiet", result, held);
        end
        en = 1'b1;
        @(posedge clk); #2;

        // enable dropped mid-conversion
        vin = 200;
        use_model = 1'b1;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        @(posedge clk); #2;
        @(posedge clk); #2;
        @(posedge clk); #2;
        en = 1'b0;
        #1;
        chk(sel == ALL_CM && !top_cm, "R9", "immediate park mid-conversion", sel, ALL_CM);
        for (int i = 0; i < NB + 2; i++) begin
            @(posedge clk); #2;
            chk(!done && result == held, "R10", "abandoned conversion", result, held);
        end
        en = 1'b1;
        for (int i = 0; i < NB + 2; i++) begin
            @(posedge clk); #2;
            chk(sel == ALL_CM && !top_cm && !done && result == held, "R10", "idle after abort", sel, ALL_CM);
        end

        // random codes, both comparator sources
        for (int n = 0; n < 40; n++) begin
            run_conv(NB'($urandom_range(0, (1 << NB) - 1)), 1, 0, 0, 0);
        end
        for (int n = 0; n < 20; n++) begin
            run_conv(NB'($urandom_range(0, (1 << NB) - 1)), 0, ($urandom_range(0, 1) == 1), 0, 0);
        end
        summary();
    end

endmodule